// File: doc/BRIEF.md
# Inclusive Set-Associative Tag Controller

This block is the tag side of a set-associative cache. It stores only a valid bit and a tag for each way, with no data array. Each request carries a byte address. The block splits the address into offset, set index and tag fields, searches every way of the indexed set in one cycle, and returns a hit or miss indication together with an access latency in cycles. Replacement follows strict least-recently-used order within each set.

On a miss, the request goes out on a next-level port that uses a valid/ready handshake, and the block waits for a response that carries a latency. If no next level is present, the miss is served at once with a fixed memory latency. The line is filled into the LRU way of the set. In inclusive mode, evicting a valid victim rebuilds the victim's block address and sends it as an invalidate to every upper-level port that is present. An incoming invalidate clears a matching line. Counters for references, misses and accumulated miss-penalty cycles are available on the outputs.

Each request completes its lookup, LRU update and fill before the next request is accepted. This keeps the order of state changes and counter updates simple and well defined.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The address splits into offset bits [OFF_W-1:0], index bits [OFF_W+IDX_W-1:OFF_W] and tag in the rest (OFF_W=log2 BLOCK_BYTES, IDX_W=log2 NUM_SETS; with defaults 3:0, 5:4, 15:6). Two addresses that differ only in the offset refer to the same line.
- R2: A request hits only when a way of the indexed set is valid and holds an equal tag. A hit sets rsp_valid with rsp_hit=1 and rsp_lat=HIT_LAT on the clock edge after the request is accepted.
- R3: A hit makes the way most recently used. Every way that was more recent than it moves one step toward least recently used.
- R4: On a miss with nl_present=1, the full request address is issued on nl_req_addr with nl_req_valid held until nl_req_ready, and rsp_lat equals the nl_rsp_lat that comes back. With nl_present=0, the miss responds on the edge after acceptance with rsp_lat=MEM_LAT.
- R5: A fill replaces the least-recently-used way of the set, and the filled line becomes most recently used. After reset the order is way 0 most recent through way NUM_WAYS-1 least recent.
- R6: With INCLUSIVE=1, a fill whose victim is valid pulses up_inv_valid together with rsp_valid, and up_inv_addr = (victim tag << (OFF_W+IDX_W)) | (index << OFF_W). A fill whose victim is invalid raises no invalidate.
- R7: The invalidate pulse is driven only on the up_inv_valid bits whose up_present bit is 1.
- R8: cnt_refs counts accepted requests, cnt_miss counts accepted misses, and cnt_pen sums the rsp_lat of every miss.
- R9: While inv_in_valid=1, the matching way in the indexed set is cleared and req_ready is 0. The LRU order of the set does not change.
- R10: While a miss is outstanding on the next-level port, req_ready stays 0.
- R11: After reset, all lines are invalid, the counters are zero, req_ready is 1, and rsp_valid and up_inv_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W | Request byte address |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Response was a hit |
| rsp_lat | output | LAT_W | Access latency in cycles |
| nl_present | input | 1 | A next level is connected |
| nl_req_valid | output | 1 | Miss request to the next level |
| nl_req_ready | input | 1 | Next level accepts the request |
| nl_req_addr | output | ADDR_W | Miss address |
| nl_rsp_valid | input | 1 | Next-level response |
| nl_rsp_lat | input | LAT_W | Latency reported by the next level |
| inv_in_valid | input | 1 | Incoming invalidate |
| inv_in_addr | input | ADDR_W | Address to invalidate |
| up_present | input | NUM_UP | Upper-level ports that are connected |
| up_inv_valid | output | NUM_UP | Back-invalidate pulse per upper port |
| up_inv_addr | output | ADDR_W | Back-invalidate block address |
| cnt_refs | output | CNT_W | Reference counter |
| cnt_miss | output | CNT_W | Miss counter |
| cnt_pen | output | CNT_W | Accumulated miss penalty |

## Verification
The bench fills one set completely, then reorders it with hits and forces evictions. If the aging rule is wrong, the wrong way is evicted, and the back-invalidate address exposes the victim's tag directly. It then invalidates a middle-aged line and misses on that same line. If an invalidate moves that way to the LRU slot, the refill takes the invalid way and raises no back-invalidate, so the absence of the expected invalidate for the true LRU victim reveals the bug. Other checks cover offset bits wrongly taken into the tag, the pass-through of latency from the next level with the stall during the miss, a mask that ignores absent upper ports, and totals in the counters that drift from the sum of the returned latencies.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_NL_REQ  = 2'd1,
    ST_NL_WAIT = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/ctag_addr_split.sv
module ctag_addr_split #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  assign idx = addr[OFF_W +: IDX_W];
  assign tag = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/ctag_way_match.sv
module ctag_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 10
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           tag,
  output logic [WAYS-1:0]            hit_oh,
  output logic                       hit
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_oh[w] = valid[w] && (tags[w] == tag);
  end
  assign hit = |hit_oh;
endmodule

// File: rtl/ctag_lru_rank.sv
module ctag_lru_rank #(
  parameter int WAYS  = 4,
  parameter int AGE_W = 2
) (
  input  logic [WAYS-1:0][AGE_W-1:0] age_in,
  input  logic [WAYS-1:0]            hit_oh,
  input  logic                       use_victim,
  output logic [WAYS-1:0][AGE_W-1:0] age_out,
  output logic [WAYS-1:0]            victim_oh
);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic [WAYS-1:0]  touch_oh;
  logic [AGE_W-1:0] touch_age;

  for (genvar w = 0; w < WAYS; w++) begin : g_vic
    assign victim_oh[w] = (age_in[w] == OLDEST);
  end

  assign touch_oh = use_victim ? victim_oh : hit_oh;

  always_comb begin
    touch_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (touch_oh[w]) touch_age = touch_age | age_in[w];
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (touch_oh[w])                 age_out[w] = '0;
      else if (age_in[w] < touch_age)  age_out[w] = age_in[w] + 1'b1;
      else                             age_out[w] = age_in[w];
    end
  end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int NUM_SETS    = 4,
  parameter int NUM_WAYS    = 4,
  parameter int BLOCK_BYTES = 16,
  parameter int HIT_LAT     = 2,
  parameter int MEM_LAT     = 20,
  parameter int INCLUSIVE   = 1,
  parameter int NUM_UP      = 2,
  parameter int LAT_W       = 8,
  parameter int CNT_W       = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [LAT_W-1:0]  rsp_lat,
  input  logic              nl_present,
  output logic              nl_req_valid,
  input  logic              nl_req_ready,
  output logic [ADDR_W-1:0] nl_req_addr,
  input  logic              nl_rsp_valid,
  input  logic [LAT_W-1:0]  nl_rsp_lat,
  input  logic              inv_in_valid,
  input  logic [ADDR_W-1:0] inv_in_addr,
  input  logic [NUM_UP-1:0] up_present,
  output logic [NUM_UP-1:0] up_inv_valid,
  output logic [ADDR_W-1:0] up_inv_addr,
  output logic [CNT_W-1:0]  cnt_refs,
  output logic [CNT_W-1:0]  cnt_miss,
  output logic [CNT_W-1:0]  cnt_pen
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(NUM_SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int AGE_W = $clog2(NUM_WAYS);

  typedef logic [NUM_SETS-1:0][NUM_WAYS-1:0]            valid_arr_t;
  typedef logic [NUM_SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0] tag_arr_t;
  typedef logic [NUM_SETS-1:0][NUM_WAYS-1:0][AGE_W-1:0] age_arr_t;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  ctl_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pend_q;
  logic              pend_en;
  valid_arr_t        valid_q, valid_d;
  tag_arr_t          tag_q, tag_d;
  age_arr_t          age_q, age_d;
  logic              arr_en;

  logic              rsp_valid_d, rsp_hit_d;
  logic [LAT_W-1:0]  rsp_lat_d;
  logic [NUM_UP-1:0] up_inv_d;
  logic [ADDR_W-1:0] up_addr_d;
  logic              inv_fire;

  logic [ADDR_W-1:0] acc_addr;
  logic [IDX_W-1:0]  acc_idx, iv_idx;
  logic [TAG_W-1:0]  acc_tag, iv_tag, vic_tag;
  logic [NUM_WAYS-1:0] acc_hit_oh, iv_hit_oh, victim_oh;
  logic              acc_hit, iv_hit;
  logic [NUM_WAYS-1:0][AGE_W-1:0] age_next;
  logic              victim_valid;

  logic              accept, hit_evt, miss_evt, fill_now, touch;
  logic [LAT_W-1:0]  fill_lat;

  // ---------------- lookup path ----------------
  assign acc_addr = (state_q == ST_IDLE) ? req_addr : pend_q;

  ctag_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split_acc (
    .addr(acc_addr), .idx(acc_idx), .tag(acc_tag)
  );
  ctag_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split_inv (
    .addr(inv_in_addr), .idx(iv_idx), .tag(iv_tag)
  );
  ctag_way_match #(.WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_match_acc (
    .valid(valid_q[acc_idx]), .tags(tag_q[acc_idx]), .tag(acc_tag),
    .hit_oh(acc_hit_oh), .hit(acc_hit)
  );
  ctag_way_match #(.WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_match_inv (
    .valid(valid_q[iv_idx]), .tags(tag_q[iv_idx]), .tag(iv_tag),
    .hit_oh(iv_hit_oh), .hit(iv_hit)
  );
  ctag_lru_rank #(.WAYS(NUM_WAYS), .AGE_W(AGE_W)) u_lru (
    .age_in(age_q[acc_idx]), .hit_oh(acc_hit_oh), .use_victim(fill_now),
    .age_out(age_next), .victim_oh(victim_oh)
  );

  always_comb begin
    vic_tag = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (victim_oh[w]) vic_tag = vic_tag | tag_q[acc_idx][w];
    end
  end
  assign victim_valid = |(victim_oh & valid_q[acc_idx]);

  // ---------------- control ----------------
  assign req_ready = (state_q == ST_IDLE) && !inv_in_valid;
  assign accept    = req_valid && req_ready;
  assign hit_evt   = accept && acc_hit;
  assign miss_evt  = accept && !acc_hit;
  assign fill_now  = (miss_evt && !nl_present) ||
                     ((state_q == ST_NL_WAIT) && nl_rsp_valid);
  assign fill_lat  = (state_q == ST_NL_WAIT) ? nl_rsp_lat : LAT_W'(MEM_LAT);
  assign touch     = hit_evt || fill_now;

  assign nl_req_valid = (state_q == ST_NL_REQ);
  assign nl_req_addr  = pend_q;

  always_comb begin
    state_d = state_q;
    pend_en = 1'b0;
    unique case (state_q)
      ST_IDLE: if (miss_evt && nl_present) begin
        state_d = ST_NL_REQ;
        pend_en = 1'b1;
      end
      ST_NL_REQ:  if (nl_req_ready) state_d = ST_NL_WAIT;
      ST_NL_WAIT: if (nl_rsp_valid) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  if (INCLUSIVE != 0) begin : g_incl
    assign inv_fire = fill_now && victim_valid;
  end else begin : g_excl
    assign inv_fire = 1'b0;
  end

  // ---------------- array next state ----------------
  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    age_d   = age_q;
    if (inv_in_valid && iv_hit)
      valid_d[iv_idx] = valid_q[iv_idx] & ~iv_hit_oh;
    if (touch)
      age_d[acc_idx] = age_next;
    if (fill_now) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (victim_oh[w]) begin
          valid_d[acc_idx][w] = 1'b1;
          tag_d[acc_idx][w]   = acc_tag;
        end
      end
    end
  end
  assign arr_en = (inv_in_valid && iv_hit) || touch;

  always_comb begin
    rsp_valid_d = hit_evt || fill_now;
    rsp_hit_d   = hit_evt;
    rsp_lat_d   = hit_evt ? LAT_W'(HIT_LAT) : fill_lat;
    up_inv_d    = inv_fire ? up_present : '0;
    up_addr_d   = {vic_tag, acc_idx, {OFF_W{1'b0}}};
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      valid_q <= '0;
      tag_q   <= '0;
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else begin
      state_q <= state_d;
      if (pend_en) pend_q <= req_addr;
      if (arr_en) begin
        valid_q <= valid_d;
        tag_q   <= tag_d;
        age_q   <= age_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_lat      <= '0;
      up_inv_valid <= '0;
      up_inv_addr  <= '0;
      cnt_refs     <= '0;
      cnt_miss     <= '0;
      cnt_pen      <= '0;
    end else begin
      rsp_valid    <= rsp_valid_d;
      up_inv_valid <= up_inv_d;
      if (rsp_valid_d) begin
        rsp_hit <= rsp_hit_d;
        rsp_lat <= rsp_lat_d;
      end
      if (inv_fire) up_inv_addr <= up_addr_d;
      if (accept)   cnt_refs <= cnt_refs + 1'b1;
      if (miss_evt) cnt_miss <= cnt_miss + 1'b1;
      if (fill_now) cnt_pen  <= cnt_pen + CNT_W'(fill_lat);
    end
  end

  // ---------------- assertions ----------------
  a_r2_hit_lat: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rsp_valid && rsp_hit) |-> (rsp_lat == LAT_W'(HIT_LAT)));

  a_r8_refs_step: assert property (@(posedge clk) disable iff (!rst_n_s)
    1'b1 |=> (cnt_refs == $past(cnt_refs)) || (cnt_refs == $past(cnt_refs) + 1'b1));

  a_r8_miss_le_refs: assert property (@(posedge clk) disable iff (!rst_n_s)
    cnt_miss <= cnt_refs);

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_ready && !acc_hit && nl_present) |=> !req_ready);

  a_r4_nl_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (nl_req_valid && !nl_req_ready) |=> (nl_req_valid && $stable(nl_req_addr)));

  a_r7_inv_mask: assert property (@(posedge clk) disable iff (!rst_n_s)
    1'b1 |=> ((up_inv_valid & ~$past(up_present)) == '0));

  a_r5_victim_onehot: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot(victim_oh));

  a_r9_inv_blocks: assert property (@(posedge clk) disable iff (!rst_n_s)
    inv_in_valid |-> !req_ready);
endmodule

// File: tb/cache_tag_ctrl_tb.sv
module cache_tag_ctrl_tb;
  localparam int AW = 16;
  localparam int LW = 8;
  localparam int CW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid, rsp_hit;
  logic [LW-1:0] rsp_lat;
  logic          nl_present = 1'b0;
  logic          nl_req_valid;
  logic          nl_req_ready = 1'b1;
  logic [AW-1:0] nl_req_addr;
  logic          nl_rsp_valid = 1'b0;
  logic [LW-1:0] nl_rsp_lat = '0;
  logic          inv_in_valid = 1'b0;
  logic [AW-1:0] inv_in_addr = '0;
  logic [1:0]    up_present = 2'b11;
  logic [1:0]    up_inv_valid;
  logic [AW-1:0] up_inv_addr;
  logic [CW-1:0] cnt_refs, cnt_miss, cnt_pen;

  cache_tag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_lat(rsp_lat),
    .nl_present(nl_present), .nl_req_valid(nl_req_valid), .nl_req_ready(nl_req_ready),
    .nl_req_addr(nl_req_addr), .nl_rsp_valid(nl_rsp_valid), .nl_rsp_lat(nl_rsp_lat),
    .inv_in_valid(inv_in_valid), .inv_in_addr(inv_in_addr),
    .up_present(up_present), .up_inv_valid(up_inv_valid), .up_inv_addr(up_inv_addr),
    .cnt_refs(cnt_refs), .cnt_miss(cnt_miss), .cnt_pen(cnt_pen)
  );

  int total = 0;
  int bad = 0;
  int exp_refs = 0, exp_miss = 0, exp_pen = 0;
  int nl_lat_cfg = 37;
  int nl_seen_cnt = 0;
  logic [AW-1:0] nl_seen_addr = '0;

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int tag, input int idx, input int off);
    return AW'((tag << 6) | (idx << 4) | off);
  endfunction

  // next-level responder: accepts at once, answers two cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (nl_req_valid && nl_req_ready) begin
        nl_seen_addr = nl_req_addr;
        nl_seen_cnt++;
        @(negedge clk);
        @(negedge clk);
        nl_rsp_valid = 1'b1;
        nl_rsp_lat   = LW'(nl_lat_cfg);
        @(negedge clk);
        nl_rsp_valid = 1'b0;
      end
    end
  end

  task automatic do_access(input logic [AW-1:0] a, input bit exp_hit, input int exp_lat,
                           input bit exp_inv, input logic [AW-1:0] exp_iaddr,
                           input logic [1:0] exp_mask, input string req);
    int waited;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!rsp_valid && waited < 50) begin
      check("R10", "req_ready during outstanding miss", int'(req_ready), 0);
      @(negedge clk);
      waited++;
    end
    check(req, "rsp_valid", int'(rsp_valid), 1);
    check(req, "rsp_hit", int'(rsp_hit), int'(exp_hit));
    check(req, "rsp_lat", int'(rsp_lat), exp_lat);
    check(exp_inv ? "R7" : "R6", "up_inv_valid", int'(up_inv_valid),
          exp_inv ? int'(exp_mask) : 0);
    if (exp_inv) check("R6", "up_inv_addr", int'(up_inv_addr), int'(exp_iaddr));
    exp_refs++;
    if (!exp_hit) begin
      exp_miss++;
      exp_pen += exp_lat;
    end
  endtask

  task automatic do_invalidate(input logic [AW-1:0] a);
    @(negedge clk);
    inv_in_valid = 1'b1;
    inv_in_addr  = a;
    #1;
    check("R9", "req_ready during invalidate", int'(req_ready), 0);
    @(negedge clk);
    inv_in_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R11", "req_ready", int'(req_ready), 1);
    check("R11", "rsp_valid", int'(rsp_valid), 0);
    check("R11", "up_inv_valid", int'(up_inv_valid), 0);
    check("R11", "cnt_refs", int'(cnt_refs), 0);
    check("R11", "cnt_miss", int'(cnt_miss), 0);
    check("R11", "cnt_pen", int'(cnt_pen), 0);
  endtask

  task automatic t_basic();
    // R1/R2/R4: compulsory miss without next level, then hit at another offset
    do_access(mk(1, 0, 0), 1'b0, 20, 1'b0, '0, 2'b00, "R4");
    do_access(mk(1, 0, 5), 1'b1, 2, 1'b0, '0, 2'b00, "R1");
    do_access(mk(2, 0, 0), 1'b0, 20, 1'b0, '0, 2'b00, "R2");
  endtask

  task automatic t_next_level();
    nl_present = 1'b1;
    nl_lat_cfg = 37;
    do_access(mk(3, 2, 9), 1'b0, 37, 1'b0, '0, 2'b00, "R4");
    check("R4", "next-level request count", nl_seen_cnt, 1);
    check("R4", "next-level address", int'(nl_seen_addr), int'(mk(3, 2, 9)));
    nl_present = 1'b0;
    do_access(mk(3, 2, 0), 1'b1, 2, 1'b0, '0, 2'b00, "R2");
  endtask

  task automatic t_lru();
    // fill set 1 with tags 1..4: victims are invalid, no back-invalidate (R6)
    for (int t = 1; t <= 4; t++)
      do_access(mk(t, 1, 0), 1'b0, 20, 1'b0, '0, 2'b00, "R6");
    do_access(mk(1, 1, 0), 1'b1, 2, 1'b0, '0, 2'b00, "R3");
    // order t1,t4,t3,t2: tag 5 evicts t2 (R5)
    do_access(mk(5, 1, 0), 1'b0, 20, 1'b1, mk(2, 1, 0), 2'b11, "R5");
    do_access(mk(1, 1, 0), 1'b1, 2, 1'b0, '0, 2'b00, "R3");
    do_access(mk(4, 1, 0), 1'b1, 2, 1'b0, '0, 2'b00, "R3");
    do_access(mk(3, 1, 0), 1'b1, 2, 1'b0, '0, 2'b00, "R3");
    // order t3,t4,t1,t5: tag 2 evicts t5, only upper port 0 present (R7)
    up_present = 2'b01;
    do_access(mk(2, 1, 0), 1'b0, 20, 1'b1, mk(5, 1, 0), 2'b01, "R7");
    up_present = 2'b11;
  endtask

  task automatic t_invalidate();
    // order t2,t3,t4,t1; invalidating t4 must not reorder, so t1 stays victim (R9)
    do_invalidate(mk(4, 1, 3));
    do_access(mk(4, 1, 0), 1'b0, 20, 1'b1, mk(1, 1, 0), 2'b11, "R9");
    do_access(mk(3, 1, 0), 1'b1, 2, 1'b0, '0, 2'b00, "R9");
    do_access(mk(2, 1, 0), 1'b1, 2, 1'b0, '0, 2'b00, "R9");
  endtask

  task automatic t_counters();
    @(negedge clk);
    check("R8", "cnt_refs", int'(cnt_refs), exp_refs);
    check("R8", "cnt_miss", int'(cnt_miss), exp_miss);
    check("R8", "cnt_pen", int'(cnt_pen), exp_pen);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_next_level();
    t_lru();
    t_invalidate();
    t_counters();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule